// File: doc/BRIEF.md
# Word-to-Byte UART Feeder

This block takes a 32-bit word, offered with a single-cycle load request, and passes it to the write port of a UART transmitter as four 8-bit bytes. The transmitter has a FIFO in front of its serializer. The feeder puts each byte on a byte bus and qualifies it with a write strobe that lasts one clock. It watches the FIFO full flag and holds the next byte back for as long as that flag is raised.

The feeder runs one transfer per load and then goes idle. While a transfer is running it reports busy and ignores any further load requests. One clock after the last byte has been written it raises a one-cycle done pulse. The serializer, the FIFO storage and the baud-rate timing belong to the transmitter and are not part of this block.

Top module: `word_byte_feeder`

## Requirements
- R1: While reset is high and after it is released, `byte_o` is 0 and `wr_o`, `busy_o` and `done_o` are all low, until a word is loaded.
- R2: A load is accepted when `load_i` is high at a clock edge and `busy_o` is low. `busy_o` is then high from the next cycle. If the FIFO is not full, the first strobe follows one cycle after that.
- R3: The bytes leave least significant first: bits 7:0, then 15:8, then 23:16, then 31:24.
- R4: Each byte has its own strobe on `wr_o`, one cycle wide. `byte_o` takes the new byte in the same cycle the strobe rises. Between strobes it keeps that value and never changes while `wr_o` is low.
- R5: When `fifo_full_i` is high at a clock edge, no strobe starts at that edge. The waiting byte is issued later with no loss and no duplication.
- R6: A `load_i` pulse that arrives while `busy_o` is high is ignored. The bytes of the running word and their count are unaffected.
- R7: `busy_o` stays high from the cycle after acceptance through the cycle that carries the fourth strobe, and drops in the next cycle.
- R8: `done_o` is a one-cycle pulse in the cycle right after the fourth strobe.
- R9: Each accepted load produces exactly four strobes. After them no further strobe occurs until a new load is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| load_i | input | 1 | Single-cycle load request |
| word_i | input | 32 | Word captured on an accepted load |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse after the last byte |
| byte_o | output | 8 | Byte bus toward the UART write port |
| wr_o | output | 1 | Write strobe qualifying `byte_o` |
| fifo_full_i | input | 1 | FIFO full flag from the UART |

## Verification
The assertions assume that `fifo_full_i` is valid at every clock edge and already reflects a write made in the previous cycle. The checker never looks at the FIFO's occupancy, so the FIFO is trusted to report its own state. The assertions also treat a load request as a level seen at a clock edge and place no limit on its length. The bench changes the full flag and the load request only at falling edges, so each value is stable across exactly one rising edge. It keeps full raised only for bounded stretches, so every transfer finishes.

// File: rtl/feeder_pkg.sv
package feeder_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEND  = 2'd1,
    ST_DRAIN = 2'd2,
    ST_DONE  = 2'd3
  } feed_state_e;

  // remaining-byte count after an optional issue
  function automatic int unsigned remaining_after(input int unsigned left, input logic issued);
    if (issued && left != 0) return left - 1;
    return left;
  endfunction

  // bit offset of byte number idx inside the word
  function automatic int unsigned byte_offset(input int unsigned idx, input int unsigned bw);
    return idx * bw;
  endfunction

endpackage

// File: rtl/feeder_shifter.sv
module feeder_shifter #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic              shift_en,
  input  logic [WORD_W-1:0] word_i,
  output logic [BYTE_W-1:0] low_byte
);
  logic [WORD_W-1:0] hold_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      hold_q <= '0;
    end else if (load_en) begin
      hold_q <= word_i;
    end else if (shift_en) begin
      hold_q <= hold_q >> BYTE_W;
    end
  end

  assign low_byte = hold_q[BYTE_W-1:0];
endmodule

// File: rtl/feeder_seq.sv
module feeder_seq
  import feeder_pkg::*;
#(
  parameter int NBYTES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load_req,
  input  logic fifo_full,
  output logic accept,
  output logic issue,
  output logic last,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(NBYTES + 1);

  feed_state_e      state_q;
  logic [CNT_W-1:0] left_q;

  assign busy   = (state_q == ST_SEND) || (state_q == ST_DRAIN);
  assign done   = (state_q == ST_DONE);
  assign accept = load_req && !busy;
  assign issue  = (state_q == ST_SEND) && !fifo_full;
  assign last   = issue && (left_q == CNT_W'(1));

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
    end else begin
      left_q <= CNT_W'(remaining_after(int'(left_q), issue));
      unique case (state_q)
        ST_IDLE, ST_DONE: begin
          if (accept) begin
            state_q <= ST_SEND;
            left_q  <= CNT_W'(NBYTES);
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_SEND:  if (last) state_q <= ST_DRAIN;
        ST_DRAIN: state_q <= ST_DONE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/feeder_out.sv
module feeder_out #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic [BYTE_W-1:0] next_byte,
  output logic [BYTE_W-1:0] byte_q,
  output logic              wr_q
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      byte_q <= '0;
      wr_q   <= 1'b0;
    end else begin
      wr_q <= issue;
      if (issue) byte_q <= next_byte;
    end
  end
endmodule

// File: rtl/word_byte_feeder.sv
module word_byte_feeder #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              wr_o,
  input  logic              fifo_full_i
);
  localparam int NBYTES = WORD_W / BYTE_W;

  // named internal events, observed by the checker
  logic              accept_w;
  logic              issue_w;
  logic              last_w;
  logic [BYTE_W-1:0] low_byte_w;

  feeder_seq #(.NBYTES(NBYTES)) u_seq (
    .clk(clk), .rst(rst), .load_req(load_i), .fifo_full(fifo_full_i),
    .accept(accept_w), .issue(issue_w), .last(last_w),
    .busy(busy_o), .done(done_o)
  );

  feeder_shifter #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst(rst), .load_en(accept_w), .shift_en(issue_w),
    .word_i(word_i), .low_byte(low_byte_w)
  );

  feeder_out #(.BYTE_W(BYTE_W)) u_out (
    .clk(clk), .rst(rst), .issue(issue_w), .next_byte(low_byte_w),
    .byte_q(byte_o), .wr_q(wr_o)
  );
endmodule

// File: rtl/feeder_checker.sv
module feeder_checker #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              load_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [BYTE_W-1:0] byte_o,
  input logic              wr_o,
  input logic              fifo_full_i,
  input logic              accept_w,
  input logic              last_w
);
  logic       past_ok;
  logic [7:0] seen_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      past_ok <= 1'b0;
      seen_q  <= '0;
    end else begin
      past_ok <= 1'b1;
      if (accept_w) seen_q <= '0;
      else if (wr_o && seen_q != 8'hFF) seen_q <= seen_q + 8'd1;
    end
  end

  p_strobe_in_busy_r7: assert property (@(posedge clk) disable iff (rst)
    wr_o |-> busy_o);
  p_no_write_when_full_r5: assert property (@(posedge clk) disable iff (rst)
    (past_ok && wr_o) |-> !$past(fifo_full_i));
  p_bus_moves_with_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    (past_ok && byte_o != $past(byte_o)) |-> wr_o);
  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  p_done_after_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    (past_ok && done_o) |-> $past(wr_o));
  p_four_strobes_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> seen_q == 8'(NBYTES));
  p_no_extra_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    wr_o |-> seen_q < 8'(NBYTES));
  p_busy_ignores_load_r6: assert property (@(posedge clk) disable iff (rst)
    (busy_o && load_i) |-> !accept_w);
  p_last_ends_busy_r7: assert property (@(posedge clk) disable iff (rst)
    last_w |=> ##1 !busy_o);
endmodule

bind word_byte_feeder feeder_checker #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_chk (
  .clk(clk), .rst(rst), .load_i(load_i), .busy_o(busy_o), .done_o(done_o),
  .byte_o(byte_o), .wr_o(wr_o), .fifo_full_i(fifo_full_i),
  .accept_w(accept_w), .last_w(last_w)
);

// File: tb/word_byte_feeder_tb.sv
module word_byte_feeder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_i = 1'b0;
  logic [31:0] word_i = '0;
  logic        fifo_full_i = 1'b0;
  logic        busy_o, done_o, wr_o;
  logic [7:0]  byte_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] mon_bytes [0:15];
  int mon_n = 0;

  always #2.5 clk = ~clk;

  word_byte_feeder u_dut (
    .clk(clk), .rst(rst), .load_i(load_i), .word_i(word_i),
    .busy_o(busy_o), .done_o(done_o), .byte_o(byte_o), .wr_o(wr_o),
    .fifo_full_i(fifo_full_i)
  );

  always @(negedge clk) begin
    if (!rst && wr_o) begin
      if (mon_n < 16) mon_bytes[mon_n] = byte_o;
      mon_n = mon_n + 1;
    end
  end

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  function automatic logic [7:0] exp_byte(input logic [31:0] w, input int i);
    return w[i*8 +: 8];
  endfunction

  task automatic check_bytes(input logic [31:0] w, input string req);
    chk(mon_n == 4, {req, " count"}, mon_n, 4);
    for (int i = 0; i < 4; i++)
      chk(mon_bytes[i] == exp_byte(w, i), req, mon_bytes[i], exp_byte(w, i));
  endtask

  task automatic start_load(input logic [31:0] w);
    word_i = w; load_i = 1'b1;
    step();
    load_i = 1'b0;
  endtask

  task automatic test_reset();
    chk(byte_o == 8'h00 && !wr_o && !busy_o && !done_o, "R1 reset state",
        {byte_o, wr_o, busy_o, done_o}, 0);
    rst = 1'b0;
    step(); step();
    chk(!busy_o && !wr_o && !done_o, "R1 idle after release", {wr_o, busy_o, done_o}, 0);
  endtask

  task automatic test_basic(input logic [31:0] w);
    mon_n = 0;
    start_load(w);
    chk(busy_o == 1'b1, "R2 busy after accept", busy_o, 1);
    chk(wr_o == 1'b0, "R2 no strobe in accept cycle", wr_o, 0);
    for (int i = 0; i < 4; i++) begin
      step();
      chk(wr_o == 1'b1, "R4 strobe per byte", wr_o, 1);
      chk(byte_o == exp_byte(w, i), "R3 byte order", byte_o, exp_byte(w, i));
      chk(busy_o == 1'b1, "R7 busy through last strobe", busy_o, 1);
    end
    step();
    chk(!wr_o && !busy_o, "R7 busy drops after last strobe", {wr_o, busy_o}, 0);
    chk(done_o == 1'b1, "R8 done after last strobe", done_o, 1);
    chk(byte_o == exp_byte(w, 3), "R4 bus held", byte_o, exp_byte(w, 3));
    step();
    chk(done_o == 1'b0, "R8 done one cycle", done_o, 0);
    for (int i = 0; i < 5; i++) step();
    chk(!wr_o && !busy_o, "R9 idle after transfer", {wr_o, busy_o}, 0);
    check_bytes(w, "R9/R3 bytes");
  endtask

  task automatic test_full_stall(input logic [31:0] w, input logic [15:0] mask);
    logic prev_full;
    mon_n = 0;
    start_load(w);
    for (int c = 0; c < 30; c++) begin
      fifo_full_i = mask[c % 16];
      prev_full = fifo_full_i;
      step();
      if (prev_full) chk(wr_o == 1'b0, "R5 no strobe while full", wr_o, 0);
    end
    fifo_full_i = 1'b0;
    step();
    chk(!busy_o, "R5 transfer completes", busy_o, 0);
    check_bytes(w, "R5 no loss or duplication");
  endtask

  task automatic test_load_busy(input logic [31:0] a, input logic [31:0] b);
    mon_n = 0;
    fifo_full_i = 1'b1;
    start_load(a);
    step();
    word_i = b; load_i = 1'b1;
    step();
    load_i = 1'b0;
    fifo_full_i = 1'b0;
    for (int i = 0; i < 5; i++) step();
    chk(done_o == 1'b1, "R6 single transfer done", done_o, 1);
    for (int i = 0; i < 4; i++) step();
    check_bytes(a, "R6 load while busy ignored");
  endtask

  task automatic test_reload_on_done(input logic [31:0] a, input logic [31:0] b);
    mon_n = 0;
    start_load(a);
    for (int i = 0; i < 4; i++) step();
    step();
    chk(done_o == 1'b1, "R8 done cycle", done_o, 1);
    word_i = b; load_i = 1'b1;
    step();
    load_i = 1'b0;
    chk(busy_o == 1'b1, "R2 accept in done cycle", busy_o, 1);
    for (int i = 0; i < 8; i++) step();
    chk(mon_n == 8, "R9 two transfers", mon_n, 8);
    for (int i = 0; i < 4; i++)
      chk(mon_bytes[4+i] == exp_byte(b, i), "R3 second word", mon_bytes[4+i], exp_byte(b, i));
  endtask

  initial begin
    #1;
    test_reset();
    test_basic(32'h44332211);
    test_basic(32'hA5F00F5A);
    test_full_stall(32'hDEADBEEF, 16'b0110_1011_0010_0111);
    test_full_stall(32'h01020304, 16'b1111_0000_0011_1100);
    test_load_busy(32'hCAFEF00D, 32'h12345678);
    test_reload_on_done(32'h00FF00FF, 32'h87654321);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule